// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block generates the bit clock and the frame (word) clock of an audio serial port running as master. It runs on a system clock and takes a one-cycle enable pulse, `base_tick`, at 256 times the sample rate. Each frame lasts 256 base ticks. In continuous mode the block emits only the bit clocks that two channels of the selected sample width need. In full mode it emits one bit clock per base tick. When the selected bit-clock rate does not divide 256, a phase accumulator places the bit-clock edges. The individual periods then differ by one base tick, but every frame holds exactly the right number of bit clocks.

A data shifter beside the block gets a one-cycle strobe at every bit-clock falling edge, the edge that launches a bit. With the strobe come the channel and the bit position within that channel's slot. The word clock can be a one-bit-period pulse or a square wave. Format inputs are sampled only at the first tick of a frame. A power-down input drops the output enable, which a pad cell uses to release both clock pins to high impedance, and it returns all state to the start of a frame. Base ticks must be at least two system clocks apart.

Top module: `aud_sclk_master`

## Requirements
- R1: In reset and after it, `bclk_o` is 1, `wclk_o`, `bit_stb`, `slot_chan` and `slot_idx` are 0. `clk_oe` is 1 from the second cycle after reset while `pwr_dn` is 0.
- R2: A frame is 256 base ticks. The first bit-clock fall of a frame is visible in the cycle after the frame's first tick. Every frame has as many rises as falls, and `bclk_o` is 1 again at the frame's end.
- R3: In continuous mode (`fmt_full`=0) a frame has 2×W bit clocks. W is 16, 20, 24 or 32 for `fmt_wid` codes 0, 1, 2 and 3.
- R4: In continuous mode, widths 16 and 32 give evenly spaced falls every 8 and 4 base ticks (32×fs and 64×fs).
- R5: In continuous mode, width 20 gives falls 6 or 7 ticks apart (average 40×fs). Width 24 gives falls 5 or 6 ticks apart (average 48×fs). Both spacings occur in every frame.
- R6: In full mode (`fmt_full`=1) a frame has exactly 256 bit clocks, one fall on every tick, for any width. Each fall is followed by a rise one system clock later.
- R7: With `fmt_pulse`=1, `wclk_o` rises at the first fall of the frame and is high at exactly one bit strobe.
- R8: With `fmt_pulse`=0, `wclk_o` is high at the strobes of the first half of the frame's bit clocks and low at the second half.
- R9: `bit_stb` is high for one cycle exactly when `bclk_o` has just fallen. At the k-th strobe of a frame of N bit clocks, `slot_chan` is 0 and `slot_idx` is k for k < N/2. Otherwise `slot_chan` is 1 and `slot_idx` is k−N/2.
- R10: A format change made mid-frame has no effect until the next frame's first tick.
- R11: Asserting `pwr_dn` clears `clk_oe` in the next cycle and returns `bclk_o` high and `wclk_o` low. While `pwr_dn` is held, no strobes occur. After release, the next tick starts a complete frame.
- R12: `wclk_o` and `slot_chan` change only together with `bit_stb`, except on the cycle a power-down takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle enable at 256×fs |
| pwr_dn | input | 1 | Power-down; releases pads and resets state |
| fmt_full | input | 1 | 1: 256 bit clocks per frame; 0: continuous |
| fmt_pulse | input | 1 | 1: pulse word clock; 0: square word clock |
| fmt_wid | input | 2 | Sample width code: 0=16, 1=20, 2=24, 3=32 |
| bclk_o | output | 1 | Bit clock level |
| wclk_o | output | 1 | Word clock level |
| clk_oe | output | 1 | Output enable for both clock pads |
| bit_stb | output | 1 | Pulse at each bit-clock falling edge |
| slot_chan | output | 1 | Channel of the current bit (0 first half, 1 second) |
| slot_idx | output | $clog2(FRAME_TICKS/2) | Bit position within the channel slot |

## Verification
The bench measures fall-to-fall spacing inside whole frames. A wrong accumulator step or carry would show up as the wrong count, as spacings outside the 6–7 or 5–6 tick window, or as uneven spacing at widths 16 and 32. Full mode is checked for one-cycle low phases. If the second carry were dropped, the frame would lose half its bit clocks and the clock would stay low. A format change in mid-frame is made on purpose. A block that applied it at once would change that frame's bit-clock count and word-clock shape. Power-down is asserted in mid-frame. If stale tick or fall counters survived it, the next frame would start off phase.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [1:0] {
        WID_16 = 2'd0,
        WID_20 = 2'd1,
        WID_24 = 2'd2,
        WID_32 = 2'd3
    } wid_e;

    typedef struct packed {
        logic full;
        logic pulse;
        wid_e wid;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{full: 1'b0, pulse: 1'b0, wid: WID_16};

    function automatic int unsigned slot_bits(wid_e w);
        case (w)
            WID_16:  return 16;
            WID_20:  return 20;
            WID_24:  return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/aclk_fmt_latch.sv
// Holds the frame format; a new format is accepted only on the first tick of a frame.
module aclk_fmt_latch
    import aclk_pkg::*;
#(
    parameter int FT = 256,
    localparam int NW = $clog2(FT) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  fmt_t          fmt_in,
    output fmt_t          fmt_eff,
    output logic [NW-1:0] bits_per_frame
);

    typedef struct packed {
        fmt_t fmt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        fmt_eff = st_q.fmt;
        if (load) begin
            st_d.fmt = fmt_in;
            fmt_eff  = fmt_in;
        end
        if (fmt_eff.full)
            bits_per_frame = NW'(FT);
        else
            bits_per_frame = NW'(2 * slot_bits(fmt_eff.wid));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{fmt: FMT_RESET};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/aclk_phase.sv
// Tick counter and edge accumulator. Each tick adds the half-period count of the
// frame; every carry out of the low bits is one bit-clock edge. A carry of two
// (full mode) gives one edge now and one on the next system clock.
module aclk_phase #(
    parameter int FT = 256,
    localparam int AW = $clog2(FT),
    localparam int SW = AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pd,
    input  logic [SW-1:0] step,
    output logic          at_start,
    output logic          toggle
);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [AW-1:0] acc;
        logic          pend;
    } st_t;

    localparam st_t ST_RESET = '{cnt: '0, acc: '1, pend: 1'b0};

    st_t           st_d, st_q;
    logic [SW-1:0] sum;
    logic [1:0]    carry;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        toggle    = st_q.pend;
        sum       = {2'b00, st_q.acc} + step;
        carry     = sum[SW-1:AW];
        if (pd) begin
            st_d   = ST_RESET;
            toggle = 1'b0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + AW'(1);
            st_d.acc = sum[AW-1:0];
            if (carry != 2'd0) toggle = 1'b1;
            if (carry == 2'd2) st_d.pend = 1'b1;
        end
    end

    assign at_start = (st_q.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/aclk_slot.sv
// Turns edge pulses into clock levels, word-clock shape and slot position.
module aclk_slot #(
    parameter int FT = 256,
    localparam int NW = $clog2(FT) + 1,
    localparam int IW = $clog2(FT / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd,
    input  logic          toggle,
    input  logic          pulse_mode,
    input  logic [NW-1:0] bits,
    output logic          bclk,
    output logic          wclk,
    output logic          stb,
    output logic          chan,
    output logic [IW-1:0] idx,
    output logic          oe
);

    typedef struct packed {
        logic          bclk;
        logic          wclk;
        logic          stb;
        logic          chan;
        logic [IW-1:0] idx;
        logic [NW-1:0] nfall;
        logic          oe;
    } st_t;

    localparam st_t ST_RESET = '{bclk: 1'b1, wclk: 1'b0, stb: 1'b0, chan: 1'b0,
                                 idx: '0, nfall: '0, oe: 1'b0};

    st_t           st_d, st_q;
    logic [NW-1:0] half;
    logic [NW-1:0] b;
    logic          upper;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.oe  = !pd;
        half     = bits >> 1;
        b        = st_q.nfall;
        upper    = (b >= half);
        if (pd) begin
            st_d    = ST_RESET;
            st_d.oe = 1'b0;
        end else if (toggle) begin
            st_d.bclk = !st_q.bclk;
            if (st_q.bclk) begin
                st_d.stb   = 1'b1;
                st_d.nfall = (b == bits - NW'(1)) ? '0 : b + NW'(1);
                st_d.chan  = upper;
                st_d.idx   = upper ? IW'(b - half) : IW'(b);
                st_d.wclk  = pulse_mode ? (b == '0) : !upper;
            end
        end
    end

    assign bclk = st_q.bclk;
    assign wclk = st_q.wclk;
    assign stb  = st_q.stb;
    assign chan = st_q.chan;
    assign idx  = st_q.idx;
    assign oe   = st_q.oe;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/aud_sclk_master.sv
module aud_sclk_master
    import aclk_pkg::*;
#(
    parameter int FRAME_TICKS = 256,
    localparam int NW = $clog2(FRAME_TICKS) + 1,
    localparam int IW = $clog2(FRAME_TICKS / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_tick,
    input  logic          pwr_dn,
    input  logic          fmt_full,
    input  logic          fmt_pulse,
    input  logic [1:0]    fmt_wid,
    output logic          bclk_o,
    output logic          wclk_o,
    output logic          clk_oe,
    output logic          bit_stb,
    output logic          slot_chan,
    output logic [IW-1:0] slot_idx
);

    fmt_t          fmt_in, fmt_eff;
    logic [NW-1:0] bits_per_frame;
    logic          at_start;
    logic          load;
    logic          toggle;

    assign fmt_in = '{full: fmt_full, pulse: fmt_pulse, wid: wid_e'(fmt_wid)};
    assign load   = base_tick && at_start && !pwr_dn;

    aclk_fmt_latch #(.FT(FRAME_TICKS)) fmt_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (load),
        .fmt_in         (fmt_in),
        .fmt_eff        (fmt_eff),
        .bits_per_frame (bits_per_frame)
    );

    aclk_phase #(.FT(FRAME_TICKS)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (base_tick),
        .pd       (pwr_dn),
        .step     ({bits_per_frame, 1'b0}),
        .at_start (at_start),
        .toggle   (toggle)
    );

    aclk_slot #(.FT(FRAME_TICKS)) slot_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd         (pwr_dn),
        .toggle     (toggle),
        .pulse_mode (fmt_eff.pulse),
        .bits       (bits_per_frame),
        .bclk       (bclk_o),
        .wclk       (wclk_o),
        .stb        (bit_stb),
        .chan       (slot_chan),
        .idx        (slot_idx),
        .oe         (clk_oe)
    );

endmodule

// File: rtl/aud_sclk_master_chk.sv
module aud_sclk_master_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn,
    input logic bclk_o,
    input logic wclk_o,
    input logic clk_oe,
    input logic bit_stb,
    input logic slot_chan
);

    // R9
    stb_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> (!bclk_o && $past(bclk_o)));

    // R11
    pd_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !clk_oe);

    // R11
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !bit_stb);

    // R12
    wclk_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wclk_o) && !$past(pwr_dn)) |-> bit_stb);

    // R12
    chan_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(slot_chan) && !$past(pwr_dn)) |-> bit_stb);

endmodule

bind aud_sclk_master aud_sclk_master_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .bclk_o    (bclk_o),
    .wclk_o    (wclk_o),
    .clk_oe    (clk_oe),
    .bit_stb   (bit_stb),
    .slot_chan (slot_chan)
);

// File: tb/aud_sclk_master_tb_top.sv
`timescale 1ns/1ps
module aud_sclk_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       base_tick;
    logic       pwr_dn;
    logic       fmt_full;
    logic       fmt_pulse;
    logic [1:0] fmt_wid;
    logic       bclk_o, wclk_o, clk_oe, bit_stb, slot_chan;
    logic [6:0] slot_idx;

    always #4 clk = ~clk;

    aud_sclk_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .pwr_dn    (pwr_dn),
        .fmt_full  (fmt_full),
        .fmt_pulse (fmt_pulse),
        .fmt_wid   (fmt_wid),
        .bclk_o    (bclk_o),
        .wclk_o    (wclk_o),
        .clk_oe    (clk_oe),
        .bit_stb   (bit_stb),
        .slot_chan (slot_chan),
        .slot_idx  (slot_idx)
    );

    // Vector table: format, then expected falls, word-clock-high strobes,
    // and min / max fall spacing in system clocks (4 clocks per tick).
    localparam int NV = 8;
    localparam int V_FULL [NV] = '{0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_PULS [NV] = '{0, 1, 0, 1, 0, 1, 0, 0};
    localparam int V_WID  [NV] = '{0, 3, 1, 2, 0, 3, 3, 2};
    localparam int V_FALL [NV] = '{32, 64, 40, 48, 256, 256, 64, 48};
    localparam int V_WHI  [NV] = '{16, 1, 20, 1, 128, 1, 32, 24};
    localparam int V_MIN  [NV] = '{32, 16, 24, 20, 4, 4, 16, 20};
    localparam int V_MAX  [NV] = '{32, 16, 28, 24, 4, 4, 16, 24};

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    int   cyc, falls, rises, lows, stbs, wh, first_fall, last_fall;
    int   min_sp, max_sp, idx_bad, exp_n;
    logic wfirst, prev_b;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_meas();
        cyc = 0; falls = 0; rises = 0; lows = 0; stbs = 0; wh = 0;
        first_fall = -1; last_fall = -1; min_sp = 1 << 20; max_sp = 0;
        idx_bad = 0; wfirst = 1'b0;
    endtask

    task automatic sample();
        bit fall;
        int half;
        fall = prev_b && !bclk_o;
        half = exp_n / 2;
        if (bit_stb !== fall) idx_bad++;
        if (bit_stb) begin
            if (stbs == 0) wfirst = wclk_o;
            if (stbs < half) begin
                if (slot_chan !== 1'b0 || int'(slot_idx) != stbs) idx_bad++;
            end else begin
                if (slot_chan !== 1'b1 || int'(slot_idx) != stbs - half) idx_bad++;
            end
            if (wclk_o) wh++;
            stbs++;
        end
        if (fall) begin
            if (first_fall < 0) first_fall = cyc;
            else begin
                if (cyc - last_fall < min_sp) min_sp = cyc - last_fall;
                if (cyc - last_fall > max_sp) max_sp = cyc - last_fall;
            end
            last_fall = cyc;
            falls++;
        end
        if (!prev_b && bclk_o) rises++;
        if (!bclk_o) lows++;
        prev_b = bclk_o;
        cyc++;
    endtask

    task automatic run_ticks(input int nt, input bit clr);
        if (clr) clear_meas();
        for (int j = 0; j < nt; j++) begin
            for (int c = 0; c < 4; c++) begin
                base_tick = (c == 0);
                @(posedge clk);
                @(negedge clk);
                base_tick = 1'b0;
                sample();
            end
        end
    endtask

    task automatic set_fmt(input int full, input int puls, input int wid);
        fmt_full  = 1'(full);
        fmt_pulse = 1'(puls);
        fmt_wid   = 2'(wid);
        exp_n     = full != 0 ? 256 : 4 * (wid == 0 ? 16 : wid == 1 ? 20 : wid == 2 ? 24 : 32) / 2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwr_dn = 1'b0; base_tick = 1'b0;
        set_fmt(0, 0, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(bclk_o === 1'b1, "R1 bclk", int'(bclk_o), 1);
        chk(wclk_o === 1'b0, "R1 wclk", int'(wclk_o), 0);
        chk(bit_stb === 1'b0, "R1 stb", int'(bit_stb), 0);
        chk(slot_chan === 1'b0 && slot_idx == 7'd0, "R1 slot", int'(slot_idx), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk(clk_oe === 1'b1, "R1 oe", int'(clk_oe), 1);
        chk(bclk_o === 1'b1, "R1 bclk idle", int'(bclk_o), 1);
        prev_b = bclk_o;

        // Table walk: one full frame per vector
        for (int v = 0; v < NV; v++) begin
            string sp_tag;
            set_fmt(V_FULL[v], V_PULS[v], V_WID[v]);
            run_ticks(256, 1'b1);
            sp_tag = V_FULL[v] != 0 ? "R6 spacing" :
                     (V_WID[v] == 1 || V_WID[v] == 2) ? "R5 spacing" : "R4 spacing";
            chk(falls == V_FALL[v], V_FULL[v] != 0 ? "R6 count" : "R3 count", falls, V_FALL[v]);
            chk(rises == falls, "R2 rises", rises, falls);
            chk(first_fall == 0, "R2 first fall", first_fall, 0);
            chk(bclk_o === 1'b1, "R2 end level", int'(bclk_o), 1);
            chk(min_sp == V_MIN[v], sp_tag, min_sp, V_MIN[v]);
            chk(max_sp == V_MAX[v], sp_tag, max_sp, V_MAX[v]);
            chk(wh == V_WHI[v], V_PULS[v] != 0 ? "R7 high strobes" : "R8 high strobes", wh, V_WHI[v]);
            chk(wfirst === 1'b1, V_PULS[v] != 0 ? "R7 first" : "R8 first", int'(wfirst), 1);
            chk(idx_bad == 0 && stbs == falls, "R9 slot", idx_bad, 0);
            if (V_FULL[v] != 0) chk(lows == 256, "R6 low cycles", lows, 256);
        end

        // R10: mid-frame format change waits for the next frame
        set_fmt(0, 0, 0);
        run_ticks(128, 1'b1);
        fmt_full = 1'b0; fmt_pulse = 1'b1; fmt_wid = 2'd3;
        run_ticks(128, 1'b0);
        chk(falls == 32, "R10 old count", falls, 32);
        chk(wh == 16, "R10 old shape", wh, 16);
        set_fmt(0, 1, 3);
        run_ticks(256, 1'b1);
        chk(falls == 64, "R10 new count", falls, 64);
        chk(wh == 1, "R10 new shape", wh, 1);

        // R11: power-down in mid-frame
        set_fmt(0, 0, 2);
        run_ticks(100, 1'b1);
        pwr_dn = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(clk_oe === 1'b0, "R11 oe off", int'(clk_oe), 0);
        chk(bclk_o === 1'b1 && wclk_o === 1'b0, "R11 levels", int'(bclk_o), 1);
        prev_b = bclk_o;
        run_ticks(50, 1'b1);
        chk(stbs == 0, "R11 quiet", stbs, 0);
        pwr_dn = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(clk_oe === 1'b1, "R11 oe on", int'(clk_oe), 1);
        set_fmt(0, 0, 1);
        run_ticks(256, 1'b1);
        chk(falls == 40, "R11 restart count", falls, 40);
        chk(first_fall == 0, "R11 restart phase", first_fall, 0);
        chk(idx_bad == 0, "R11 restart slot", idx_bad, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule